// File: doc/BRIEF.md
# Cycle-Counting Interrupt Down-Counter

This block holds a 16-bit count that steps down by one on every CPU cycle in which it is running, and raises a level interrupt request when the count wraps from zero to all ones. Software reaches it through a small write-only register port. A 2-bit select chooses one of three targets: a control register, the low count byte, or the high count byte. Address decoding is done outside the block. The block receives only the select, the data byte, a write strobe and a per-CPU-cycle enable.

Counting and interrupt generation have separate enable bits, so the count can run and wrap quietly with the interrupt masked. A raised request stays up until software writes the control register. That control write is the only acknowledge. Further wraps while the request is pending do not change it.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the count is 0x0000, both enables are clear and `irq_o` is low. Setting both enables with no load gives `irq_o` high after exactly one tick.
- R2: A control write takes data bit 0 as the interrupt enable and data bit 7 as the count enable. Bits 6:1 have no effect.
- R3: Select encoding: 0 is control, 1 is the count low byte, 2 is the count high byte. A write with select 3 changes nothing.
- R4: A low-byte write replaces count bits 7:0 and keeps bits 15:8.
- R5: A high-byte write replaces count bits 15:8 and keeps bits 7:0.
- R6: With the count enable set, each cycle with `tick_i` high decrements the count modulo 65536. Cycles without `tick_i`, or with the count enable clear, leave the count unchanged.
- R7: Suppose the count is N and both enables are set. `irq_o` rises at the clock edge of the (N+1)-th tick, which is the tick that wraps 0x0000 to 0xFFFF. This holds for N = 0x0000 as well, and a count of 0xFFFF needs 65536 ticks.
- R8: With the count enable set and the interrupt enable clear, the count keeps wrapping and `irq_o` stays low.
- R9: Once high, `irq_o` stays high through later ticks, wraps and count writes until a control write or reset.
- R10: Every control write drives `irq_o` low at the next edge. This includes a write in the same cycle as a wrapping tick.
- R11: If a count-byte write and a decrement fall in the same cycle, the written byte takes the data value. The other byte takes its value from the decremented count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per CPU cycle |
| wr_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register select (0 control, 1 low byte, 2 high byte) |
| data_i | input | 8 | Write data |
| irq_o | output | 1 | Level interrupt request, active high |

## Verification
The bench sweeps small load values plus 0x00FF, 0x0100 and 0xFFFF. It measures the ticks to the interrupt against N+1: an off-by-one detector, or one that fires on reaching zero rather than on the wrap, misses every point of the sweep. It also runs with gapped ticks, so a counter that steps on every clock shows up. It writes a count byte in the same cycle as a tick; a design that lets the decrement win takes hundreds of ticks instead of a handful. It lands a control write on a wrapping tick, and a design where set beats acknowledge leaves the request high. Masked-interrupt wraps, ignored control bits and select 3 are each followed by a measured run, which exposes any hidden change to the count or the enables.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_CNT_LO = 2'd1,
    SEL_CNT_HI = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_IRQ_BIT = 0;
  localparam int unsigned CTRL_RUN_BIT = 7;
endpackage

// File: rtl/cit_ctrl.sv
module cit_ctrl
  import cyc_irq_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              run_en_o,
  output logic              irq_en_o,
  output logic              ack_o
);
  assign ack_o = wr_i && (sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_en_o <= 1'b0;
      irq_en_o <= 1'b0;
    end else if (ack_o) begin
      run_en_o <= data_i[CTRL_RUN_BIT];
      irq_en_o <= data_i[CTRL_IRQ_BIT];
    end
  end
endmodule

// File: rtl/cit_count.sv
module cit_count
  import cyc_irq_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);
  localparam int unsigned N_LANES = CNT_W / BYTE_W;

  logic [CNT_W-1:0] cnt_q, dec, cnt_d;

  assign dec    = step_i ? cnt_q - CNT_W'(1) : cnt_q;
  assign wrap_o = step_i && (cnt_q == '0);

  // byte write overrides the decremented value in its own lane only
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    logic lane_wr;
    assign lane_wr = wr_i && (int'(sel_i) == int'(SEL_CNT_LO) + i);
    assign cnt_d[i*BYTE_W +: BYTE_W] = lane_wr ? data_i : dec[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cit_irq.sv
module cit_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  // acknowledge beats a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_o <= 1'b0;
    else if (clr_i)  irq_o <= 1'b0;
    else if (set_i)  irq_o <= 1'b1;
  end
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              irq_o
);
  logic             run_en, irq_en, ack, step, wrap;
  logic [CNT_W-1:0] cnt_q;

  cit_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .sel_i    (sel_i),
    .data_i   (data_i),
    .run_en_o (run_en),
    .irq_en_o (irq_en),
    .ack_o    (ack)
  );

  assign step = tick_i && run_en;

  cit_count #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .wr_i   (wr_i),
    .sel_i  (sel_i),
    .data_i (data_i),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  cit_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wrap && irq_en),
    .clr_i  (ack),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic [1:0]        sel_i,
  input logic [BYTE_W-1:0] data_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              run_en,
  input logic              irq_en
);
  logic ctrl_wr, cnt_wr;
  assign ctrl_wr = wr_i && (sel_i == 2'd0);
  assign cnt_wr  = wr_i && (sel_i == 2'd1 || sel_i == 2'd2);

  p_ack_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !irq_o);
  p_irq_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ctrl_wr |=> irq_o);
  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !irq_en |=> !irq_o);
  p_rise_on_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !ctrl_wr && !(tick_i && run_en && irq_en && cnt_q == '0) |=> !irq_o);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && run_en) && !cnt_wr |=> $stable(cnt_q));
  p_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && run_en && !cnt_wr |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)));
  p_lo_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && sel_i == 2'd1 |=> cnt_q[BYTE_W-1:0] == $past(data_i));
  p_hi_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && sel_i == 2'd2 |=> cnt_q[2*BYTE_W-1:BYTE_W] == $past(data_i));
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .wr_i   (wr_i),
  .sel_i  (sel_i),
  .data_i (data_i),
  .irq_o  (irq_o),
  .cnt_q  (cnt_q),
  .run_en (run_en),
  .irq_en (irq_en)
);

// File: tb/cyc_irq_timer_tb.sv
module cyc_irq_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [1:0] sel_i = 2'd0;
  logic [7:0] data_i = 8'd0;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cyc_irq_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .sel_i(sel_i), .data_i(data_i), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; tick_i = 1'b0; wr_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_i = 1'b1; sel_i = s; data_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic load(input int n);
    wr(2'd1, n[7:0]);
    wr(2'd2, n[15:8]);
  endtask

  // ticks every cycle (gap=0) or every other cycle (gap=1) until irq_o rises
  task automatic run_to_irq(input bit gap, input int limit, output int ticks);
    ticks = 0;
    for (int c = 0; c < limit; c++) begin
      if (irq_o) break;
      tick_i = gap ? c[0] : 1'b1;
      if (tick_i) ticks++;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
    if (!irq_o) ticks = -1;
  endtask

  task automatic measure(input int n, input bit gap, input string req);
    int t;
    do_reset();
    load(n);
    wr(2'd0, 8'h81);
    run_to_irq(gap, 140000, t);
    chk(t == n + 1, req, t, n + 1);
  endtask

  initial begin
    int t;
    // R1 reset state
    do_reset();
    chk(irq_o == 1'b0, "R1 irq low after reset", irq_o, 0);
    wr(2'd0, 8'h81);
    run_to_irq(1'b0, 10, t);
    chk(t == 1, "R1 reset count zero", t, 1);

    // R7 sweep of small loads, back-to-back ticks; R6 with gapped ticks
    for (int n = 0; n < 24; n++) measure(n, 1'b0, "R7 ticks to irq");
    for (int n = 0; n < 12; n++) measure(n, 1'b1, "R6 gapped ticks");
    measure(16'h00FF, 1'b0, "R7 load 0x00FF");
    measure(16'h0100, 1'b0, "R7 load 0x0100 R4 R5");
    measure(16'h0A5C, 1'b1, "R4 R5 byte merge");
    measure(16'hFFFF, 1'b0, "R7 full period");

    // R2 ignored control bits, run disabled keeps count
    do_reset();
    load(5);
    wr(2'd0, 8'h7E);
    tick_i = 1'b1;
    repeat (40) @(negedge clk_i);
    tick_i = 1'b0;
    chk(irq_o == 1'b0, "R2 middle bits no enable", irq_o, 0);
    wr(2'd0, 8'hFF);
    run_to_irq(1'b0, 100, t);
    chk(t == 6, "R2 count held, 0xFF acts as both enables", t, 6);

    // R3 select 3 ignored
    do_reset();
    load(7);
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'h81);
    run_to_irq(1'b0, 100, t);
    chk(t == 8, "R3 select 3 ignored", t, 8);

    // R4 low write keeps high byte, R5 high write keeps low byte
    do_reset();
    load(16'h0203);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h81);
    run_to_irq(1'b0, 1000, t);
    chk(t == 16'h0201, "R4 high byte kept", t, 16'h0201);
    do_reset();
    load(16'h0203);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h81);
    run_to_irq(1'b0, 1000, t);
    chk(t == 4, "R5 low byte kept", t, 4);

    // R8 masked wraps keep running; then unmask at 0xFFFF
    do_reset();
    load(2);
    wr(2'd0, 8'h80);
    tick_i = 1'b1;
    repeat (3) @(negedge clk_i);
    tick_i = 1'b0;
    chk(irq_o == 1'b0, "R8 masked wrap no irq", irq_o, 0);
    wr(2'd0, 8'h81);
    run_to_irq(1'b0, 70000, t);
    chk(t == 65536, "R8 count wrapped to 0xFFFF", t, 65536);

    // R9 pending irq holds through ticks, wraps and count writes
    load(0);
    tick_i = 1'b1;
    repeat (50) @(negedge clk_i);
    tick_i = 1'b0;
    chk(irq_o == 1'b1, "R9 irq held", irq_o, 1);
    // R10 control write acknowledges
    wr(2'd0, 8'h81);
    chk(irq_o == 1'b0, "R10 control write clears", irq_o, 1'b0);

    // R10 ack in same cycle as wrapping tick
    do_reset();
    wr(2'd0, 8'h81);
    tick_i = 1'b1;
    wr(2'd0, 8'h81);
    tick_i = 1'b0;
    chk(irq_o == 1'b0, "R10 ack beats wrap", irq_o, 0);
    tick_i = 1'b1;
    repeat (5) @(negedge clk_i);
    tick_i = 1'b0;
    chk(irq_o == 1'b0, "R10 count at 0xFFFF after wrap", irq_o, 0);

    // R11 byte write beats decrement
    do_reset();
    load(16'h0100);
    wr(2'd0, 8'h81);
    tick_i = 1'b1;
    wr(2'd1, 8'h05);
    run_to_irq(1'b0, 1000, t);
    chk(t == 6, "R11 low write with tick", t, 6);
    do_reset();
    load(16'h0203);
    wr(2'd0, 8'h81);
    tick_i = 1'b1;
    wr(2'd2, 8'h01);
    run_to_irq(1'b0, 1000, t);
    chk(t == 16'h0103, "R11 high write with tick", t, 16'h0103);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 195000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule